// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block sits on a two-wire I2C bus as a target and behaves like a small serial EEPROM. It samples SCL and SDA on a fast system clock through two-flop synchronizers and finds bus conditions and clock edges on that clock. A transaction opens with a control byte that carries a device code, a chip-select field and a direction bit. A write is followed by two address bytes and one data byte. A read is formed from a dummy write that loads the address, then a repeated START, then a control byte with the read bit. For a read, the target shifts the stored byte out. SDA is never driven high. The block only pulls the line low through an enable output, which the pad or the bench combines with the pull-up. The block does not do page writes, sequential reads, a write-busy period, clock stretching or write protection.

The address on the bus is 13 bits wide: the low five bits of the high byte, then the low byte. The storage holds 2^MEM_AW bytes (default MEM_AW = 10, range 9 to 13). Address bits at and above MEM_AW are ignored, and so are the top three bits of the high byte.

The controller is a single state machine. IDLE waits for a START. CTRL receives the control byte. On its eighth falling SCL edge it goes to CTRL_ACK if the code and select match, and to IGNORE if they do not. From CTRL_ACK the next falling edge leads to AHI for a write or to RDAT for a read. The byte-receive states follow one chain: AHI to AHI_ACK to ALO to ALO_ACK to WDAT to WDAT_ACK. Each receive state moves to its ACK state on its eighth falling edge, and each ACK state moves on at the next falling edge. WDAT_ACK then goes to IGNORE. RDAT goes to RDAT_ACK after the eighth data clock, and RDAT_ACK goes to IGNORE on the following falling edge. A START seen in any state leads to CTRL. A STOP seen in any state leads to IDLE and clears the loaded address and the direction.

Top module: `i2c_ee_target`

## Requirements
- R1: After an active-low asynchronous reset, sda_oe is 0 and every storage byte reads as 0x00.
- R2: A START is SDA falling while SCL is high. The control byte that follows is taken most significant bit first on rising SCL edges, laid out as code 1010 in bits 7:4, select in bits 3:1 and direction in bit 0 (0 = write, 1 = read).
- R3: For every byte the target accepts, it holds sda_oe at 1 through the ninth SCL clock. It returns sda_oe to 0 within a few system clocks after that clock's falling edge.
- R4: If the select bits differ from strap_sel, the target gives no acknowledge, ignores the rest of the bus traffic until the next START, and leaves the storage unchanged.
- R5: If the device code in bits 7:4 is not 1010, the target behaves the same way as in R4.
- R6: A write (START, control with bit 0 = 0, address high, address low, data, STOP) stores the data byte at address {high[4:0], low}.
- R7: A random read (a dummy write of the two address bytes, a repeated START, control with bit 0 = 1) returns the stored byte most significant bit first. Each bit changes only after a falling SCL edge and stays stable through the whole SCL high phase.
- R8: After the eighth read data bit the target releases SDA for the master's ninth clock, so the master's NACK appears on the bus.
- R9: A STOP in any state returns the block to IDLE and clears the loaded address. A later read control byte that is not preceded by address bytes therefore reads address 0.
- R10: A START that arrives in the middle of a byte restarts reception of the control byte from its first bit.
- R11: Address bits at and above MEM_AW, and bits 7:5 of the high byte, do not affect which byte is accessed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 cycles per SCL period |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_sel | input | 3 | Select value that control bits 3:1 must match |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench is the bus master. It plays out random single-byte writes and random reads against a byte-array model, and adds directed cases around them. The directed cases are:
- A write to a high byte that has its top bits set, read back through an address with those bits clear. A design that decodes too many bits would return zero instead of the stored byte.
- Control bytes with a wrong select and with a wrong device code. A target that acknowledged these, or stored their data, would show up as a pulled-low ninth clock or a corrupted byte on a later read.
- A START in the middle of a byte. A target that kept its partial bit count would misread the control byte that follows.
- A STOP placed straight after the address bytes, then a read with no address bytes. A target that did not clear its address on STOP would return the wrong byte.
- Read data sampled twice in each SCL high phase, and the line checked during the master's ninth clock. This catches read data that changes too late and a target that keeps holding SDA during the master's ninth clock.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RDAT_ACK,
        ST_IGNORE
    } ee_state_e;

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [2:0] scl_pipe;
    logic [2:0] sda_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '0;
            sda_pipe <= '0;
        end else begin
            scl_pipe <= {scl_pipe[1:0], scl_i};
            sda_pipe <= {sda_pipe[1:0], sda_i};
        end
    end

    // bit 1 is the synchronized value, bit 2 the value one cycle earlier
    assign sda_s     = sda_pipe[1];
    assign scl_rise  = scl_pipe[1] & ~scl_pipe[2];
    assign scl_fall  = ~scl_pipe[1] & scl_pipe[2];
    assign start_det = scl_pipe[1] & scl_pipe[2] & sda_pipe[2] & ~sda_pipe[1];
    assign stop_det  = scl_pipe[1] & scl_pipe[2] & ~sda_pipe[2] & sda_pipe[1];

endmodule

// File: rtl/ee_store.sv
module ee_store #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wr_data,
    output logic [7:0]    rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
        end else if (wr_en) begin
            cells[addr] <= wr_data;
        end
    end

    assign rd_data = cells[addr];

endmodule

// File: rtl/i2c_ee_target.sv
module i2c_ee_target #(
    parameter int MEM_AW = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] strap_sel,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe
);
    import i2c_ee_pkg::*;

    localparam int HI_W = MEM_AW - 8;

    ee_state_e         state_q, state_d;
    logic [3:0]        bit_cnt_q;
    logic [7:0]        shreg_q;
    logic [MEM_AW-1:0] addr_q;
    logic              rd_q;
    logic              oe_q;
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]        rd_data;
    logic              sel_ok, byte_done, rx_state, wr_en;

    i2c_bus_sampler u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    ee_store #(.AW(MEM_AW)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr_q),
        .wr_data(shreg_q),
        .rd_data(rd_data)
    );

    assign sel_ok    = (shreg_q[7:4] == DEV_CODE) && (shreg_q[3:1] == strap_sel);
    assign byte_done = scl_fall && (bit_cnt_q == 4'd8);
    assign rx_state  = (state_q == ST_CTRL) || (state_q == ST_AHI) ||
                       (state_q == ST_ALO)  || (state_q == ST_WDAT);
    assign wr_en     = (state_q == ST_WDAT) && byte_done;
    assign sda_oe    = oe_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_CTRL;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_CTRL:     if (byte_done) state_d = sel_ok ? ST_CTRL_ACK : ST_IGNORE;
                ST_CTRL_ACK: if (scl_fall)  state_d = rd_q ? ST_RDAT : ST_AHI;
                ST_AHI:      if (byte_done) state_d = ST_AHI_ACK;
                ST_AHI_ACK:  if (scl_fall)  state_d = ST_ALO;
                ST_ALO:      if (byte_done) state_d = ST_ALO_ACK;
                ST_ALO_ACK:  if (scl_fall)  state_d = ST_WDAT;
                ST_WDAT:     if (byte_done) state_d = ST_WDAT_ACK;
                ST_WDAT_ACK: if (scl_fall)  state_d = ST_IGNORE;
                ST_RDAT:     if (scl_fall && bit_cnt_q == 4'd7) state_d = ST_RDAT_ACK;
                ST_RDAT_ACK: if (scl_fall)  state_d = ST_IGNORE;
                ST_IGNORE:   state_d = ST_IGNORE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // datapath and SDA enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            addr_q    <= '0;
            rd_q      <= 1'b0;
            oe_q      <= 1'b0;
        end else if (stop_det) begin
            bit_cnt_q <= '0;
            addr_q    <= '0;
            rd_q      <= 1'b0;
            oe_q      <= 1'b0;
        end else if (start_det) begin
            bit_cnt_q <= '0;
            oe_q      <= 1'b0;
        end else begin
            if (rx_state && scl_rise) begin
                shreg_q   <= {shreg_q[6:0], sda_s};
                bit_cnt_q <= bit_cnt_q + 4'd1;
            end
            if (rx_state && byte_done) begin
                bit_cnt_q <= '0;
                oe_q      <= (state_q == ST_CTRL) ? sel_ok : 1'b1;
                if (state_q == ST_CTRL) rd_q <= shreg_q[0];
                if (state_q == ST_AHI)  addr_q[MEM_AW-1:8] <= shreg_q[HI_W-1:0];
                if (state_q == ST_ALO)  addr_q[7:0] <= shreg_q;
            end
            if (scl_fall) begin
                unique case (state_q)
                    ST_CTRL_ACK: begin
                        if (rd_q) begin
                            shreg_q   <= rd_data;
                            oe_q      <= ~rd_data[7];
                            bit_cnt_q <= '0;
                        end else begin
                            oe_q <= 1'b0;
                        end
                    end
                    ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: oe_q <= 1'b0;
                    ST_RDAT: begin
                        bit_cnt_q <= bit_cnt_q + 4'd1;
                        if (bit_cnt_q == 4'd7) begin
                            oe_q <= 1'b0;
                        end else begin
                            oe_q    <= ~shreg_q[6];
                            shreg_q <= {shreg_q[6:0], 1'b0};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // checks beside the logic they guard
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt_q <= 4'd8);

    assert_oe_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    assert_ignore_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !sda_oe);

    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE && !sda_oe));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_oe);

endmodule

// File: tb/sim_i2c_ee_target.sv
`timescale 1ns/1ps
module sim_i2c_ee_target;

    localparam int MEM_AW = 10;
    localparam logic [2:0] SEL = 3'b101;
    localparam logic [7:0] CW = {4'b1010, SEL, 1'b0};
    localparam logic [7:0] CR = {4'b1010, SEL, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;
    int   nvec = 0;
    int   nbad = 0;
    logic [7:0] model [1 << MEM_AW];

    always #2.5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_ee_target #(.MEM_AW(MEM_AW)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_sel(SEL),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe)
    );

    function automatic int idx(input logic [7:0] hi, input logic [7:0] lo);
        logic [12:0] full;
        full = {hi[4:0], lo};
        return int'(full[MEM_AW-1:0]);
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_io(input logic b, output logic s);
        cyc(4); sda_m = b;
        cyc(4); scl_m = 1'b1;
        cyc(4); s = sda_bus;
        cyc(4); scl_m = 1'b0;
    endtask

    task automatic do_start();
        cyc(4); sda_m = 1'b1;
        cyc(4); scl_m = 1'b1;
        cyc(4); sda_m = 1'b0;
        cyc(4); scl_m = 1'b0;
    endtask

    task automatic do_stop();
        cyc(4); sda_m = 1'b0;
        cyc(4); scl_m = 1'b1;
        cyc(4); sda_m = 1'b1;
        cyc(8);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked, output logic released);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(v[i], s);
        bit_io(1'b1, s);
        acked = !s;
        cyc(6);
        released = !sda_oe;
    endtask

    task automatic recv_byte(output logic [7:0] d, output logic stable, output logic nack_free);
        logic a, b, s;
        stable = 1'b1;
        d = '0;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            cyc(8); scl_m = 1'b1;
            cyc(2); a = sda_bus;
            cyc(4); b = sda_bus;
            cyc(2); scl_m = 1'b0;
            d = {d[6:0], a};
            if (a !== b) stable = 1'b0;
        end
        bit_io(1'b1, s);
        nack_free = s;
    endtask

    task automatic wr_txn(input logic [7:0] ctl, input logic [7:0] hi, input logic [7:0] lo,
                          input logic [7:0] d, input logic exp_ack, input string req);
        logic a, r;
        do_start();
        send_byte(ctl, a, r); chk({req, " ack control"}, a, exp_ack);
        if (exp_ack) chk("R3 release after control ack", r, 1'b1);
        send_byte(hi, a, r);  chk({req, " ack addr hi"}, a, exp_ack);
        send_byte(lo, a, r);  chk({req, " ack addr lo"}, a, exp_ack);
        send_byte(d, a, r);   chk({req, " ack data"}, a, exp_ack);
        if (exp_ack) chk("R3 release after data ack", r, 1'b1);
        do_stop();
        if (exp_ack) model[idx(hi, lo)] = d;
    endtask

    task automatic rd_txn(input logic [7:0] hi, input logic [7:0] lo, output logic [7:0] d);
        logic a, r, st, nf;
        do_start();
        send_byte(CW, a, r); chk("R2 ack dummy write control", a, 1'b1);
        send_byte(hi, a, r); chk("R3 ack read addr hi", a, 1'b1);
        send_byte(lo, a, r); chk("R3 ack read addr lo", a, 1'b1);
        do_start();
        send_byte(CR, a, r); chk("R7 ack read control", a, 1'b1);
        recv_byte(d, st, nf);
        chk("R7 data stable during SCL high", st, 1'b1);
        chk("R8 SDA released for master ninth clock", nf, 1'b1);
        do_stop();
    endtask

    task automatic rd_check(input logic [7:0] hi, input logic [7:0] lo, input string req);
        logic [7:0] d;
        rd_txn(hi, lo, d);
        chk(req, d, model[idx(hi, lo)]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        logic [7:0] hs [30];
        logic [7:0] ls [30];
        logic [7:0] d;
        logic a, r, st, nf;
        for (int i = 0; i < (1 << MEM_AW); i++) model[i] = 8'h00;
        void'($urandom(32'h5eed));
        cyc(5);
        chk("R1 sda_oe low in reset", sda_oe, 1'b0);
        rst_n = 1'b1;
        cyc(10);
        chk("R1 sda_oe low after reset", sda_oe, 1'b0);
        rd_check(8'h00, 8'h37, "R1 storage reads zero after reset");

        // R6 directed write then read
        wr_txn(CW, 8'h03, 8'hFF, 8'h5A, 1'b1, "R6");
        rd_check(8'h03, 8'hFF, "R6 stored byte at top address");

        // R11 upper address bits ignored
        wr_txn(CW, 8'hFE, 8'h10, 8'hC3, 1'b1, "R11");
        rd_check(8'h02, 8'h10, "R11 aliased address");

        // R4 select mismatch
        wr_txn({4'b1010, 3'b100, 1'b0}, 8'h00, 8'h20, 8'h77, 1'b0, "R4 no ack");
        rd_check(8'h00, 8'h20, "R4 storage untouched");

        // R5 wrong device code
        wr_txn({4'b1011, SEL, 1'b0}, 8'h00, 8'h21, 8'h66, 1'b0, "R5 no ack");
        rd_check(8'h00, 8'h21, "R5 storage untouched");

        // R10 START in the middle of a byte
        do_start();
        bit_io(1'b0, a); bit_io(1'b1, a); bit_io(1'b1, a);
        wr_txn(CW, 8'h01, 8'h44, 8'hE7, 1'b1, "R10");
        rd_check(8'h01, 8'h44, "R10 write after mid-byte START");

        // R9 STOP clears the loaded address
        wr_txn(CW, 8'h00, 8'h00, 8'h9C, 1'b1, "R9");
        wr_txn(CW, 8'h01, 8'h05, 8'h11, 1'b1, "R9");
        do_start();
        send_byte(CW, a, r); send_byte(8'h01, a, r); send_byte(8'h05, a, r);
        do_stop();
        do_start();
        send_byte(CR, a, r); chk("R9 ack read control", a, 1'b1);
        recv_byte(d, st, nf);
        do_stop();
        chk("R9 read after STOP uses address 0", d, 8'h9C);

        // random writes and reads
        for (int i = 0; i < 30; i++) begin
            hs[i] = 8'($urandom);
            ls[i] = 8'($urandom);
            wr_txn(CW, hs[i], ls[i], 8'($urandom), 1'b1, "R6 random");
        end
        for (int i = 0; i < 30; i++) begin
            if (i % 3 == 2) rd_check(8'($urandom), 8'($urandom), "R7 random read");
            else            rd_check(hs[29 - i], ls[29 - i], "R7 read back");
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule